// File: doc/BRIEF.md
# Switching Clock Synchronizer

This block generates the switching-period timing for a fixed-frequency PWM controller. A period counter runs at the system clock and wraps after a programmable number of cycles. Each wrap gives a one-cycle ramp-reset strobe and starts the high half of a square switching clock. Halfway through every free-running period, the block drives a fixed-width pulse onto a shared synchronization line.

The same line is sampled as an input. A pulse from outside that stays high long enough is accepted, and the counter restarts at once, with no phase shift. A device whose own period is shorter than that of its neighbour therefore paces the neighbour. The neighbour's periods then begin half a period after the master's own starts. A period started from outside issues no sync pulse, so a slave never drives the shared line back at its master.

The input is masked while the block drives its own pulse. A lock flag shows that the block is following an external source. When a period is cut short by an accepted pulse, the count the ramp had reached is held on an output. The sync input is taken to be synchronous to the system clock already. The system-clock period is 4 ns.

Top module: `switch_clk_sync`

## Requirements
- R1: While reset is active, ramp_rst is 1, sw_clk is 1, sync_oe is 0, synced is 0 and trunc_count is 0.
- R2: With no accepted sync pulse, ramp_rst pulses for one cycle every P cycles. P is period_len, except that period_len = 0 selects 1000 cycles (the 250 kHz default) and a value below 250 (the 1 MHz limit) is raised to 250.
- R3: sw_clk is 1 in the ramp_rst cycle and in the floor(P/2)-1 cycles after it, and 0 for the rest of the period.
- R4: In a free-running period, sync_oe rises exactly floor(P/2) cycles after the ramp_rst cycle and stays 1 for exactly 28 cycles.
- R5: A high level on sync_in lasting fewer than 18 consecutive sampled cycles is ignored and leaves the period unchanged.
- R6: When sync_in has been sampled high for 18 consecutive cycles, ramp_rst is 1 in the very next cycle and the period counts again from zero.
- R7: sync_in is ignored in every cycle in which sync_oe is 1, and a run of high samples is not carried across such a cycle.
- R8: sync_oe stays 0 for the whole of any period that an accepted sync pulse started.
- R9: On an accepted pulse, trunc_count takes the number of cycles between the last ramp_rst cycle and the cycle of the 18th high sample. trunc_count changes at no other time.
- R10: synced becomes 1 in the ramp_rst cycle that follows the second accepted pulse with no internal wrap between them. It returns to 0 in the ramp_rst cycle that follows a full internal period with no accepted pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| period_len | input | 12 | Requested switching period in system-clock cycles (0 selects the default) |
| sync_in | input | 1 | Sampled level of the shared sync line |
| sync_oe | output | 1 | Drive enable for the block's own sync pulse |
| ramp_rst | output | 1 | One-cycle strobe at each period start; resets the ramp |
| sw_clk | output | 1 | Switching clock, high in the first half of the period |
| synced | output | 1 | Set while locked to an external sync source |
| trunc_count | output | 12 | Count reached when the last period was cut short by an accepted pulse |

## Verification
Several rules are checked on every cycle: the exact width of the outgoing pulse, that it never overlaps a period start, and that a locked slave never drives the line. The checks also require that sw_clk is high at each period start and that lock and trunc_count change only at a period start. Other behaviour depends on timing across whole periods and only the bench scenarios can show it. That covers the wrap point after clamping and the default, the half-period offset of the pulse, and rejection of a 17-cycle pulse against acceptance of an 18-cycle one. It also covers masking during the block's own pulse and the restart position with its truncated count. The lock sequence, set on a second consecutive pulse and cleared after one silent period, is shown the same way.

// File: rtl/swsync_pkg.sv
package swsync_pkg;

  typedef enum logic [1:0] {
    LK_FREE = 2'd0,
    LK_ONE  = 2'd1,
    LK_HELD = 2'd2
  } lock_e;

  function automatic int effective_period(input int req, input int dflt, input int fastest);
    if (req == 0)            return dflt;
    else if (req < fastest)  return fastest;
    else                     return req;
  endfunction

endpackage

// File: rtl/swsync_qualifier.sv
module swsync_qualifier #(
  parameter int IN_CYC = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic mask,
  output logic accept
);
  localparam int HW = $clog2(IN_CYC + 1);
  localparam logic [HW-1:0] HI_LAST = HW'(IN_CYC - 1);
  localparam logic [HW-1:0] HI_SAT  = HW'(IN_CYC);

  logic [HW-1:0] hi_q, hi_n;
  logic          live;

  always_comb begin
    live   = sync_in & ~mask;
    accept = live && (hi_q == HI_LAST);
    if (!live)                hi_n = '0;
    else if (hi_q == HI_SAT)  hi_n = hi_q;
    else                      hi_n = hi_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_n;
  end
endmodule

// File: rtl/swsync_period_ctr.sv
module swsync_period_ctr #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] per_eff,
  input  logic          accept,
  output logic          ramp_rst,
  output logic          sw_clk,
  output logic          expire,
  output logic          half_load,
  output logic [PW-1:0] trunc_count
);
  logic [PW-1:0] cnt_q, cnt_n, trunc_q, trunc_n, half;
  logic          start_q, start_n, ext_q, ext_n, wrap;

  always_comb begin
    half   = per_eff >> 1;
    wrap   = (cnt_q >= per_eff - 1'b1);
    expire = wrap && !accept;
    if (accept) begin
      cnt_n = '0; start_n = 1'b1; ext_n = 1'b1;
    end else if (wrap) begin
      cnt_n = '0; start_n = 1'b1; ext_n = 1'b0;
    end else begin
      cnt_n = cnt_q + 1'b1; start_n = 1'b0; ext_n = ext_q;
    end
    trunc_n   = accept ? cnt_q : trunc_q;
    half_load = (cnt_n == half) && !ext_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      start_q <= 1'b1;
      ext_q   <= 1'b0;
      trunc_q <= '0;
    end else begin
      cnt_q   <= cnt_n;
      start_q <= start_n;
      ext_q   <= ext_n;
      trunc_q <= trunc_n;
    end
  end

  assign ramp_rst    = start_q;
  assign sw_clk      = (cnt_q < half);
  assign trunc_count = trunc_q;
endmodule

// File: rtl/swsync_pulse_gen.sv
module swsync_pulse_gen #(
  parameter int OUT_CYC = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic sync_oe
);
  localparam int CW = $clog2(OUT_CYC + 1);
  localparam logic [CW-1:0] LEN = CW'(OUT_CYC);

  logic [CW-1:0] left_q, left_n;

  always_comb begin
    if (load)              left_n = LEN;
    else if (left_q != '0) left_n = left_q - 1'b1;
    else                   left_n = left_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_n;
  end

  assign sync_oe = (left_q != '0);
endmodule

// File: rtl/swsync_lock_fsm.sv
module swsync_lock_fsm
  import swsync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic expire,
  output logic synced
);
  lock_e st_q, st_n;

  always_comb begin
    st_n = st_q;
    if (expire) st_n = LK_FREE;
    else if (accept) begin
      unique case (st_q)
        LK_FREE: st_n = LK_ONE;
        LK_ONE:  st_n = LK_HELD;
        default: st_n = LK_HELD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_FREE;
    else        st_q <= st_n;
  end

  assign synced = (st_q == LK_HELD);
endmodule

// File: rtl/switch_clk_sync.sv
module switch_clk_sync
  import swsync_pkg::*;
#(
  parameter int PER_W          = 12,
  parameter int DEFAULT_PERIOD = 1000,
  parameter int FAST_PERIOD    = 250,
  parameter int OUT_CYC        = 28,
  parameter int IN_CYC         = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_len,
  input  logic             sync_in,
  output logic             sync_oe,
  output logic             ramp_rst,
  output logic             sw_clk,
  output logic             synced,
  output logic [PER_W-1:0] trunc_count
);
  logic             rst_m_q, rst_int_n;
  logic [PER_W-1:0] per_eff;
  logic             accept, expire, half_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q   <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_m_q   <= 1'b1;
      rst_int_n <= rst_m_q;
    end
  end

  always_comb begin
    per_eff = PER_W'(effective_period(int'(period_len), DEFAULT_PERIOD, FAST_PERIOD));
  end

  swsync_qualifier #(.IN_CYC(IN_CYC)) u_qual (
    .clk(clk), .rst_n(rst_int_n), .sync_in(sync_in), .mask(sync_oe), .accept(accept)
  );

  swsync_period_ctr #(.PW(PER_W)) u_ctr (
    .clk(clk), .rst_n(rst_int_n), .per_eff(per_eff), .accept(accept),
    .ramp_rst(ramp_rst), .sw_clk(sw_clk), .expire(expire),
    .half_load(half_load), .trunc_count(trunc_count)
  );

  swsync_pulse_gen #(.OUT_CYC(OUT_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_int_n), .load(half_load), .sync_oe(sync_oe)
  );

  swsync_lock_fsm u_lock (
    .clk(clk), .rst_n(rst_int_n), .accept(accept), .expire(expire), .synced(synced)
  );
endmodule

// File: rtl/swsync_checker.sv
module swsync_checker #(
  parameter int PER_W   = 12,
  parameter int OUT_CYC = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_oe,
  input logic             ramp_rst,
  input logic             sw_clk,
  input logic             synced,
  input logic [PER_W-1:0] trunc_count
);
  localparam int RW = $clog2(OUT_CYC + 2);
  logic [RW-1:0] oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          oe_run <= '0;
    else if (!sync_oe)                   oe_run <= '0;
    else if (oe_run != RW'(OUT_CYC + 1)) oe_run <= oe_run + 1'b1;
  end

  assert_oe_max_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_oe |-> (oe_run < RW'(OUT_CYC)));
  assert_oe_full_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_oe) |-> (oe_run == RW'(OUT_CYC)));
  assert_oe_not_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_oe |-> !ramp_rst);
  assert_sw_high_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_rst |-> sw_clk);
  assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    synced |-> !sync_oe);
  assert_lock_on_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> ramp_rst);
  assert_trunc_on_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trunc_count) |-> ramp_rst);
endmodule

bind switch_clk_sync swsync_checker #(.PER_W(PER_W), .OUT_CYC(OUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .sync_oe(sync_oe), .ramp_rst(ramp_rst),
  .sw_clk(sw_clk), .synced(synced), .trunc_count(trunc_count)
);

// File: tb/test_switch_clk_sync.sv
`timescale 1ns/1ps
module test_switch_clk_sync;
  localparam int PW = 12;
  localparam int OUTW = 28;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PW-1:0] period_len;
  logic          sync_in;
  logic          sync_oe, ramp_rst, sw_clk, synced;
  logic [PW-1:0] trunc_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  switch_clk_sync i_switch_clk_sync (
    .clk(clk), .rst_n(rst_n), .period_len(period_len), .sync_in(sync_in),
    .sync_oe(sync_oe), .ramp_rst(ramp_rst), .sw_clk(sw_clk), .synced(synced),
    .trunc_count(trunc_count)
  );

  // requested period, expected effective period
  localparam int TBL [5][2] = '{'{300, 300}, '{0, 1000}, '{100, 250}, '{251, 251}, '{4000, 4000}};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int plen);
    period_len = PW'(plen);
    sync_in = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (!ramp_rst) break;
    end
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (ramp_rst) break;
    end
  endtask

  // Called at a negedge inside a ramp_rst cycle (t=0); returns at the next one.
  task automatic run_period(input int ps, input int pl, output int per, output int f_oe,
                            output int n_oe, output int n_sw, output int lk1, output int lk_end);
    per = 0; f_oe = -1; n_oe = 0; n_sw = 0; lk1 = 0; lk_end = 0;
    for (int k = 1; k <= 6000; k++) begin
      @(negedge clk);
      if (ramp_rst) begin
        per = k; lk_end = int'(synced); sync_in = 1'b0;
        break;
      end
      if (sync_oe) begin
        n_oe++;
        if (f_oe < 0) f_oe = k;
      end
      if (sw_clk) n_sw++;
      if (k == 1) lk1 = int'(synced);
      sync_in = (k >= ps) && (k < ps + pl);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int per, f_oe, n_oe, n_sw, lk1, lk_end;
    rst_n = 1'b0;
    sync_in = 1'b0;
    period_len = PW'(300);
    repeat (3) @(negedge clk);
    // R1: values held during reset
    check("R1 ramp_rst", int'(ramp_rst), 1);
    check("R1 sw_clk", int'(sw_clk), 1);
    check("R1 sync_oe", int'(sync_oe), 0);
    check("R1 synced", int'(synced), 0);
    check("R1 trunc_count", int'(trunc_count), 0);

    // Free-running periods, clamping and default (R2, R3, R4)
    for (int i = 0; i < 5; i++) begin
      do_reset(TBL[i][0]);
      run_period(0, 0, per, f_oe, n_oe, n_sw, lk1, lk_end);
      check("R2 period", per, TBL[i][1]);
      check("R3 sw_clk high cycles", n_sw, TBL[i][1] / 2 - 1);
      check("R4 sync_oe offset", f_oe, TBL[i][1] / 2);
      check("R4 sync_oe width", n_oe, OUTW);
    end

    do_reset(400);
    // R5: a 17-cycle pulse is ignored
    run_period(50, 17, per, f_oe, n_oe, n_sw, lk1, lk_end);
    check("R5 short pulse period", per, 400);
    check("R5 trunc unchanged", int'(trunc_count), 0);
    // R6 / R9: an 18-cycle pulse restarts the period at once
    run_period(100, 18, per, f_oe, n_oe, n_sw, lk1, lk_end);
    check("R6 restart period", per, 118);
    check("R9 trunc_count", int'(trunc_count), 117);
    check("R10 single pulse no lock", lk_end, 0);
    // R8 / R10: second consecutive pulse locks; slave period emits nothing
    run_period(100, 18, per, f_oe, n_oe, n_sw, lk1, lk_end);
    check("R6 second restart", per, 118);
    check("R8 no sync_oe in slave period", n_oe, 0);
    check("R10 lock set", lk_end, 1);
    // R10: a silent full period releases the lock
    run_period(0, 0, per, f_oe, n_oe, n_sw, lk1, lk_end);
    check("R2 silent period", per, 400);
    check("R8 no sync_oe after restart", n_oe, 0);
    check("R10 lock held during period", lk1, 1);
    check("R10 lock cleared", lk_end, 0);
    check("R9 trunc held on wrap", int'(trunc_count), 117);
    // R7: a pulse during the block's own sync_oe is masked
    run_period(200, 28, per, f_oe, n_oe, n_sw, lk1, lk_end);
    check("R7 masked pulse period", per, 400);
    check("R7 own pulse width", n_oe, OUTW);
    check("R7 trunc unchanged", int'(trunc_count), 117);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule